// File: doc/BRIEF.md
# Configurable-Format Serial Transmitter

This block turns bytes written over a register port into asynchronous serial frames on one output line. A format register picks one of six character layouts: 8 or 9 data bits without parity, or 7 or 8 data bits followed by an even or odd parity bit. A start bit comes first and a stop bit comes last, so every frame is 10 or 11 bit times long. A control register enables the transmitter, requests break characters, and gates the two transmitter flags onto a single interrupt line. Bit timing comes from an external baud tick, and the shifter moves one bit per tick.

Data enters through the register port, not through a valid/ready stream. A write to the data register is always accepted. Back-pressure is left to software, which polls the empty flag or waits for its interrupt before it writes again. A write made while a byte is still pending replaces that byte. The ninth data bit comes from a separate input pin and is captured in the same write.

Top module: `tx_serial_top`

## Requirements
- R1: After reset the format register and the control register read 0. The status register reads empty=1 and done=1. `tx_line` is high and `irq` is low.
- R2: A frame starts with one low start bit. Its payload bits follow, least significant first, and it ends with one high stop bit. The frame is 10 bit times long when format bit 0 (`wide`) is 0 and 11 bit times long when it is 1.
- R3: When format bit 1 (`par_en`) is 1, the highest payload slot holds a parity bit computed over the data bits below it. There are 7 data bits when wide=0 and 8 when wide=1. Format bit 2 (`par_odd`) set to 0 gives even parity and set to 1 gives odd parity. `par_odd` has no effect when par_en=0.
- R4: With wide=1 and par_en=0, the ninth data bit sent is the level of `bit9_in` sampled during the data register write.
- R5: Register addresses are 0 for format, 1 for control, 2 for data and 3 for status. Control bits, from bit 7 down to bit 0, are: transmit-empty interrupt enable, done interrupt enable, receive interrupt enable, idle interrupt enable, transmitter enable, receiver enable, wakeup, and send break. Every control bit reads back as written. Status bit 7 is empty and status bit 6 is done.
- R6: A data register write clears empty. Empty sets when the pending byte moves into the shifter.
- R7: A data register write clears done. Done sets when the shifter finishes a frame while no byte is pending and send break is 0.
- R8: `irq` is high exactly when (empty and the empty interrupt enable are both 1) or (done and the done interrupt enable are both 1).
- R9: While transmitter enable and send break are both 1 and no byte is pending, the line is held low for one full frame length (10 or 11 ticks). This repeats, with one clock of high line between breaks, for as long as send break stays set.
- R10: With transmitter enable at 0, no pending byte moves into the shifter and the idle line stays high.
- R11: While a frame is in progress, `tx_line` changes only on the clock edge that follows a baud tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | ADDR_W | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data of the selected register (combinational) |
| bit9_in | input | 1 | Ninth data bit, captured on a data register write |
| baud_tick | input | 1 | One-clock pulse per bit time |
| tx_line | output | 1 | Serial output, idles high |
| irq | output | 1 | Transmitter interrupt request |

## Verification
The bench uses the default parameters: an 8-bit register port and a 2-bit address. In this configuration all eight combinations of the three format bits can be swept, including the two in which `par_odd` must have no effect, each with sixty-six data patterns and an alternating ninth bit. Every bit slot of every frame is compared with a frame built arithmetically in the bench. The small register map also lets the bench check each interrupt gating case and read back the flag transitions at the ports. It measures break length in ticks for the 11-bit frame.

// File: rtl/tx_serial_pkg.sv
package tx_serial_pkg;
  localparam int unsigned ADDR_FMT  = 0;
  localparam int unsigned ADDR_CTL  = 1;
  localparam int unsigned ADDR_DAT  = 2;
  localparam int unsigned ADDR_STAT = 3;

  typedef struct packed {
    logic par_odd;
    logic par_en;
    logic wide;
  } fmt_t;

  typedef struct packed {
    logic tx_ie;
    logic done_ie;
    logic rx_ie;
    logic idle_ie;
    logic tx_en;
    logic rx_en;
    logic wake;
    logic brk;
  } ctl_t;
endpackage

// File: rtl/tx_serial_regs.sv
module tx_serial_regs
  import tx_serial_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic              bit9_in,
  input  logic              load,
  input  logic              frame_end,
  output fmt_t              fmt,
  output ctl_t              ctl,
  output logic [REG_W:0]    hold,
  output logic              hold_full,
  output logic              st_empty,
  output logic              st_done,
  output logic              irq
);
  logic wr_fmt, wr_ctl, wr_dat;

  assign wr_fmt = wr && (addr == ADDR_W'(ADDR_FMT));
  assign wr_ctl = wr && (addr == ADDR_W'(ADDR_CTL));
  assign wr_dat = wr && (addr == ADDR_W'(ADDR_DAT));

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt       <= '0;
      ctl       <= '0;
      hold      <= '0;
      hold_full <= 1'b0;
      st_empty  <= 1'b1;
      st_done   <= 1'b1;
    end else begin
      if (wr_fmt) fmt <= fmt_t'(wdata[2:0]);
      if (wr_ctl) ctl <= ctl_t'(wdata[7:0]);
      if (wr_dat) hold <= {bit9_in, wdata};
      hold_full <= wr_dat | (hold_full & ~load);
      if (wr_dat)    st_empty <= 1'b0;
      else if (load) st_empty <= 1'b1;
      if (wr_dat) st_done <= 1'b0;
      else if (frame_end && !hold_full && !ctl.brk) st_done <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(ADDR_FMT): rdata[2:0] = fmt;
      ADDR_W'(ADDR_CTL): rdata[7:0] = ctl;
      ADDR_W'(ADDR_DAT): rdata      = hold[REG_W-1:0];
      ADDR_W'(ADDR_STAT): begin
        rdata[REG_W-1] = st_empty;
        rdata[REG_W-2] = st_done;
      end
      default: rdata = '0;
    endcase
  end

  assign irq = (ctl.tx_ie & st_empty) | (ctl.done_ie & st_done);
endmodule

// File: rtl/tx_serial_framer.sv
module tx_serial_framer
  import tx_serial_pkg::*;
#(
  parameter int REG_W = 8,
  localparam int FW = REG_W + 3,
  localparam int LW = $clog2(FW + 1)
) (
  input  fmt_t           fmt,
  input  logic [REG_W:0] data,
  output logic [FW-1:0]  frame,
  output logic [LW-1:0]  len
);
  logic [REG_W:0] payload;
  logic           par;
  int unsigned    pos;

  always_comb begin
    payload = fmt.wide ? data : {1'b1, data[REG_W-1:0]};
    pos     = fmt.wide ? REG_W : REG_W - 1;
    par     = fmt.par_odd;
    for (int i = 0; i < REG_W; i++) begin
      if (i < pos) par = par ^ data[i];
    end
    if (fmt.par_en) payload[pos] = par;
    frame = {1'b1, payload, 1'b0};
    len   = fmt.wide ? LW'(FW) : LW'(FW - 1);
  end
endmodule

// File: rtl/tx_serial_shifter.sv
module tx_serial_shifter #(
  parameter int REG_W = 8,
  localparam int FW = REG_W + 3,
  localparam int LW = $clog2(FW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          tx_en,
  input  logic          brk,
  input  logic          hold_full,
  input  logic [FW-1:0] frame,
  input  logic [LW-1:0] len,
  output logic          load,
  output logic          frame_end,
  output logic          busy,
  output logic          line
);
  logic [FW-1:0] sh;
  logic [LW-1:0] cnt;
  logic          start_brk;

  assign load      = !busy && tx_en && hold_full;
  assign start_brk = !busy && tx_en && brk && !hold_full;
  assign frame_end = busy && tick && (cnt == LW'(1));
  assign line      = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      sh   <= '1;
      cnt  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      sh   <= frame;
      cnt  <= len;
    end else if (start_brk) begin
      busy <= 1'b1;
      sh   <= '0;
      cnt  <= len;
    end else if (busy && tick) begin
      sh  <= {1'b1, sh[FW-1:1]};
      cnt <= cnt - LW'(1);
      if (cnt == LW'(1)) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/tx_serial_top.sv
module tx_serial_top
  import tx_serial_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int ADDR_W = 2,
  localparam int FW = REG_W + 3,
  localparam int LW = $clog2(FW + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              bit9_in,
  input  logic              baud_tick,
  output logic              tx_line,
  output logic              irq
);
  fmt_t           fmt;
  ctl_t           ctl;
  logic [REG_W:0] hold;
  logic           hold_full, st_empty, st_done;
  logic           sh_load, sh_end, sh_busy;
  logic [FW-1:0]  frame;
  logic [LW-1:0]  len;

  tx_serial_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
    .rdata(reg_rdata), .bit9_in(bit9_in), .load(sh_load), .frame_end(sh_end),
    .fmt(fmt), .ctl(ctl), .hold(hold), .hold_full(hold_full),
    .st_empty(st_empty), .st_done(st_done), .irq(irq)
  );

  tx_serial_framer #(.REG_W(REG_W)) u_framer (
    .fmt(fmt), .data(hold), .frame(frame), .len(len)
  );

  tx_serial_shifter #(.REG_W(REG_W)) u_shift (
    .clk(clk), .rst(rst), .tick(baud_tick), .tx_en(ctl.tx_en), .brk(ctl.brk),
    .hold_full(hold_full), .frame(frame), .len(len), .load(sh_load),
    .frame_end(sh_end), .busy(sh_busy), .line(tx_line)
  );
endmodule

// File: rtl/tx_serial_chk.sv
module tx_serial_chk #(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              busy,
  input logic              line,
  input logic              load,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic              empty,
  input logic              done,
  input logic              tx_ie,
  input logic              done_ie,
  input logic              irq
);
  logic wr_dat;
  assign wr_dat = wr && (addr == ADDR_W'(2));

  assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !line);

  assert_hold_between_ticks_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(tick)) |-> $stable(line));

  assert_load_sets_empty_R6: assert property (@(posedge clk) disable iff (rst)
    (load && !wr_dat) |=> empty);

  assert_write_clears_flags_R7: assert property (@(posedge clk) disable iff (rst)
    wr_dat |=> (!empty && !done));

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (rst)
    (!tx_ie && !done_ie) |-> !irq);

  assert_irq_empty_R8: assert property (@(posedge clk) disable iff (rst)
    (tx_ie && empty) |-> irq);
endmodule

bind tx_serial_top tx_serial_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .tick(baud_tick), .busy(sh_busy), .line(tx_line),
  .load(sh_load), .wr(reg_wr), .addr(reg_addr), .empty(st_empty),
  .done(st_done), .tx_ie(ctl.tx_ie), .done_ie(ctl.done_ie), .irq(irq)
);

// File: tb/tx_serial_top_test.sv
module tx_serial_top_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       bit9_in = 1'b0;
  logic       baud_tick = 1'b0;
  logic       tx_line, irq;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  int tdiv = 0;

  tx_serial_top uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bit9_in(bit9_in),
    .baud_tick(baud_tick), .tx_line(tx_line), .irq(irq)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    tdiv <= (tdiv == 3) ? 0 : tdiv + 1;
    baud_tick <= (tdiv == 3);
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      fails = fails + 1;
      tests = tests + 1;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(string req, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_tick();
    do @(posedge clk); while (!baud_tick);
    @(negedge clk);
  endtask

  function automatic logic [10:0] exp_frame(input logic [2:0] f, input logic [7:0] d,
                                            input logic b9);
    logic [10:0] fr;
    logic [8:0]  all;
    int m, pen, nd, ones;
    fr = '1;
    all = {b9, d};
    m = f[0]; pen = f[1];
    nd = 8 + m - pen;
    ones = 0;
    fr[0] = 1'b0;
    for (int i = 0; i < nd; i++) begin
      fr[i + 1] = all[i];
      ones += all[i];
    end
    if (pen != 0) fr[nd + 1] = ((ones % 2) != 0) ^ f[2];
    fr[9 + m] = 1'b1;
    return fr;
  endfunction

  task automatic capture(input int n, output logic [10:0] got);
    got = '1;
    while (tx_line) @(negedge clk);
    got[0] = tx_line;
    for (int i = 1; i < n; i++) begin
      wait_tick();
      got[i] = tx_line;
    end
    wait_tick();
  endtask

  initial begin
    logic [7:0]  r;
    logic [10:0] got, exp;
    int          n;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(2'd0, r); check("R1 fmt", r, 8'h00);
    rd(2'd1, r); check("R1 ctl", r, 8'h00);
    rd(2'd3, r); check("R1 status", r, 8'hC0);
    check("R1 line", tx_line, 1);
    check("R1 irq", irq, 0);

    // R5 readback and R8 gating
    wr(2'd1, 8'hF6); rd(2'd1, r); check("R5 ctl readback", r, 8'hF6);
    check("R8 irq empty gate", irq, 1);
    wr(2'd1, 8'h40); #1 check("R8 irq done gate", irq, 1);
    wr(2'd1, 8'h30); #1 check("R8 irq masked", irq, 0);
    wr(2'd0, 8'h05); rd(2'd0, r); check("R5 fmt readback", r, 8'h05);

    // R10 disabled: data pending, no transfer
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h3C);
    rd(2'd3, r); check("R6 R7 write clears flags", r, 8'h00);
    wr(2'd1, 8'hC0); #1 check("R8 irq with flags low", irq, 0);
    repeat (60) @(negedge clk);
    check("R10 line idle while disabled", tx_line, 1);
    rd(2'd3, r); check("R10 byte still pending", r, 8'h00);
    wr(2'd1, 8'hC8);
    while (tx_line) @(negedge clk);
    rd(2'd3, r); check("R6 empty after transfer", r, 8'h80);
    check("R8 irq from empty", irq, 1);
    got = '1; got[0] = 1'b0;
    for (int i = 1; i < 10; i++) begin wait_tick(); got[i] = tx_line; end
    wait_tick();
    check("R2 frame after enable", got, exp_frame(3'd0, 8'h3C, 1'b0));
    rd(2'd3, r); check("R7 done after frame", r, 8'hC0);
    wr(2'd1, 8'h08);

    // R2 R3 R4 R11 format sweep
    for (int f = 0; f < 8; f++) begin
      wr(2'd0, 8'(f));
      n = 10 + (f & 1);
      for (int i = 0; i < 66; i++) begin
        logic [7:0] d;
        d = (i == 64) ? 8'h00 : (i == 65) ? 8'hFF : 8'((i * 37 + f * 11) & 255);
        bit9_in = (i & 1) != ((f >> 2) & 1);
        wr(2'd2, d);
        capture(n, got);
        exp = exp_frame(3'(f), d, bit9_in);
        if ((f & 2) != 0) check("R3 parity frame", got, exp);
        else if ((f & 1) != 0) check("R4 ninth bit frame", got, exp);
        else check("R2 plain frame", got, exp);
        check("R2 idle after stop", tx_line, 1);
      end
      rd(2'd3, r); check("R7 done after sweep", r, 8'hC0);
    end

    // R9 break, 11-bit frame
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h09);
    while (tx_line) @(negedge clk);
    n = 0;
    while (!tx_line && n < 40) begin wait_tick(); n++; end
    check("R9 break length", n, 11);
    @(negedge clk);
    check("R9 break repeats", tx_line, 0);
    wr(2'd1, 8'h08);
    repeat (60) @(negedge clk);
    check("R9 line high after break cleared", tx_line, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule